// File: doc/BRIEF.md
# Receive Word Packer with Idle Timeout

This block sits behind a serial receiver's deserializer. Each received byte is placed into a 32-bit word, the first byte of a word in the lowest lane, and every completed word goes into a small word FIFO that software drains one word at a time. A fill level in words and a ready flag tell software when words are waiting.

Software starts a transfer by writing an expected byte count. From then on, a running count of accepted bytes is kept. When the line goes quiet for a programmable number of character times while a partial word or unread words remain, a stale event fires. The event pushes the partial word into the FIFO with its unused lanes set to zero, raises a sticky flag and latches the running byte count. Software can then tell which bytes of the last word are padding. Commands enable, disable, force and clear the stale event.

Top module: `rxp_word_packer`

## Requirements
- R1: Accepted bytes fill a word from bits [7:0] upward, with the n-th byte of a word in bits [8n+7:8n]. The word is pushed into the FIFO in the cycle its fourth byte is accepted.
- R2: `rx_level` gives the number of stored words, from 0 up to DEPTH. `rx_ready` is high exactly when `rx_level` is at least 1. Both read 0 after reset.
- R3: `rd_word` always shows the oldest stored word. A cycle with `rd_en` high removes that word. With the FIFO empty, `rd_word` reads 0 and `rd_en` leaves the level at 0.
- R4: `arm_wr` loads `arm_count` as the expected byte count, clears the running count, discards any partial word and re-opens the snapshot. A byte offered in the same cycle as `arm_wr` is dropped.
- R5: A byte is accepted only while the running count is below the expected count, and every other byte is dropped. The expected count is 0 after reset, so no byte is accepted before the first arm.
- R6: The idle timer restarts on every byte on the input. The timer advances on `char_tick` only while the event is enabled, the flag is clear, and a partial word or a stored word exists. It fires on the N-th tick with no byte, where N is `stale_chars`, and a value of 0 selects 4.
- R7: In the cycle a stale event fires (timed or forced), any partial word is pushed zero-padded, including a byte accepted in that same cycle. `stale_flag` rises on the same clock edge.
- R8: The first stale event after an arm latches into `snap_total` the running count, including a byte accepted in that cycle. Later events leave `snap_total` unchanged until the next arm. `snap_total` is 0 after reset.
- R9: `cmd_op` codes: 0 none, 1 enable the stale event, 2 disable it, 3 force a stale event, 4 clear `stale_flag`. The event is disabled after reset. A forced event fires whether or not the event is enabled.
- R10: A word completed while the FIFO holds DEPTH words and no word is read in that cycle is lost, and the level stays at DEPTH.
- R11: With no partial word and no stored word, character ticks never raise `stale_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte_vld | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| char_tick | input | 1 | One-cycle pulse per character time |
| arm_wr | input | 1 | Start a transfer |
| arm_count | input | CNT_W (16) | Expected byte count loaded by `arm_wr` |
| cmd_op | input | 3 | Stale command code (R9) |
| stale_chars | input | LIM_W (4) | Idle character times before a stale event, 0 selects 4 |
| rd_en | input | 1 | Remove the oldest word |
| rd_word | output | WORD_W (32) | Oldest stored word, 0 when empty |
| rx_level | output | clog2(DEPTH+1) (7) | Stored words |
| rx_ready | output | 1 | At least one word stored |
| stale_flag | output | 1 | Sticky stale event flag |
| snap_total | output | CNT_W (16) | Latched byte count of the current transfer |

## Verification
Every result is due one clock edge after its stimulus. A byte that completes a word, a read, an arm, a command or the tick on which the timer fires shows up on `rx_level`, `rd_word`, `stale_flag` and `snap_total` right after the next rising edge, with no extra pipeline stage. The bench drives inputs just after a falling edge. A behavioural model updates on the rising edge from the same inputs, and all five outputs are compared with it at the following falling edge, half a cycle after the edge that changed them. Literal checks on the key points, such as the tick count to expiry, the padded words and the latched counts, are sampled at those same falling edges.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   typedef enum logic [2:0] {
      OP_NONE        = 3'd0,
      OP_STALE_ON    = 3'd1,
      OP_STALE_OFF   = 3'd2,
      OP_STALE_FORCE = 3'd3,
      OP_STALE_CLR   = 3'd4
   } stale_op_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rxp_lane_packer.sv
module rxp_lane_packer #(
   parameter int WORD_W = 32
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         accept,
   input  logic [7:0]                                   byte_in,
   input  logic                                         flush_req,
   input  logic                                         discard,
   output logic                                         push,
   output logic [WORD_W-1:0]                            word,
   output logic [$clog2(WORD_W/rxp_pkg::BYTE_W)-1:0]    fill
);
   localparam int LANES = WORD_W / rxp_pkg::BYTE_W;
   localparam int IDX_W = $clog2(LANES);

   logic [7:0]       lane_q [LANES];
   logic [7:0]       lane_d [LANES];
   logic [IDX_W-1:0] idx_q;
   logic             last_lane;
   logic             clear_lanes;

   assign last_lane   = accept && (idx_q == IDX_W'(LANES - 1));
   assign push        = !discard && (last_lane || (flush_req && (accept || (idx_q != '0))));
   assign clear_lanes = discard || push;
   assign fill        = idx_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_d[g] = (accept && (idx_q == IDX_W'(g))) ? byte_in : lane_q[g];
      assign word[g*8 +: 8] = lane_d[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (clear_lanes) begin
            lane_q[g] <= '0;
         end else begin
            lane_q[g] <= lane_d[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear_lanes) begin
         idx_q <= '0;
      end else if (accept) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/rxp_word_fifo.sv
module rxp_word_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DATA_W-1:0]            din,
   input  logic                         pop_req,
   output logic [DATA_W-1:0]            dout,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int AW    = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [LVL_W-1:0]  cnt_q;
   logic              empty;
   logic              full;
   logic              do_pop;
   logic              do_push;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == LVL_W'(DEPTH));
   assign do_pop  = pop_req && !empty;
   assign do_push = push && (!full || do_pop);
   assign level   = cnt_q;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         if (do_push && !do_pop) begin
            cnt_q <= cnt_q + LVL_W'(1);
         end else if (do_pop && !do_push) begin
            cnt_q <= cnt_q - LVL_W'(1);
         end
      end
   end
endmodule

// File: rtl/rxp_stale_ctrl.sv
module rxp_stale_ctrl #(
   parameter int CNT_W     = 16,
   parameter int LIM_W     = 4,
   parameter int DEF_STALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             byte_seen,
   input  logic             pending,
   input  logic [2:0]       cmd_op,
   input  logic [LIM_W-1:0] limit_cfg,
   input  logic             arm,
   input  logic [CNT_W-1:0] total_nxt,
   output logic             fire,
   output logic             flag,
   output logic [CNT_W-1:0] snap,
   output logic             snap_lock
);
   import rxp_pkg::*;

   stale_op_e        op;
   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt_q;
   logic             en_q;
   logic             flag_q;
   logic             expire;
   logic             hold_cnt;

   assign op     = stale_op_e'(cmd_op);
   assign limit  = (limit_cfg == '0) ? LIM_W'(DEF_STALE) : limit_cfg;
   assign expire = en_q && !flag_q && pending && !byte_seen && tick &&
                   (cnt_q == (limit - LIM_W'(1)));
   assign fire   = (op == OP_STALE_FORCE) || expire;
   assign hold_cnt = byte_seen || !pending || flag_q || !en_q || fire || (op == OP_STALE_CLR);
   assign flag   = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold_cnt) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + LIM_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (op == OP_STALE_ON) begin
            en_q <= 1'b1;
         end else if (op == OP_STALE_OFF) begin
            en_q <= 1'b0;
         end
         if (op == OP_STALE_CLR) begin
            flag_q <= 1'b0;
         end else if (fire) begin
            flag_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap      <= '0;
         snap_lock <= 1'b0;
      end else if (arm) begin
         snap_lock <= 1'b0;
      end else if (fire && !snap_lock) begin
         snap      <= total_nxt;
         snap_lock <= 1'b1;
      end
   end
endmodule

// File: rtl/rxp_word_packer.sv
module rxp_word_packer #(
   parameter int WORD_W    = 32,
   parameter int DEPTH     = 64,
   parameter int CNT_W     = 16,
   parameter int LIM_W     = 4,
   parameter int DEF_STALE = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_byte_vld,
   input  logic [7:0]                   rx_byte,
   input  logic                         char_tick,
   input  logic                         arm_wr,
   input  logic [CNT_W-1:0]             arm_count,
   input  logic [2:0]                   cmd_op,
   input  logic [LIM_W-1:0]             stale_chars,
   input  logic                         rd_en,
   output logic [WORD_W-1:0]            rd_word,
   output logic [$clog2(DEPTH+1)-1:0]   rx_level,
   output logic                         rx_ready,
   output logic                         stale_flag,
   output logic [CNT_W-1:0]             snap_total
);
   localparam int LANES = WORD_W / rxp_pkg::BYTE_W;
   localparam int IDX_W = $clog2(LANES);

   if ((WORD_W % rxp_pkg::BYTE_W) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power-of-two count of bytes, at least two");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DEF_STALE < 1 || DEF_STALE >= (1 << LIM_W)) begin : g_bad_stale
      $error("DEF_STALE must fit in LIM_W bits and be nonzero");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   logic [CNT_W-1:0]  total_q;
   logic [CNT_W-1:0]  expect_q;
   logic [CNT_W-1:0]  total_nxt;
   logic              accept;
   logic              pk_push;
   logic [WORD_W-1:0] pk_word;
   logic [IDX_W-1:0]  pack_idx;
   logic              pending;
   logic              stale_fire;
   logic              snap_lock;

   assign accept    = rx_byte_vld && !arm_wr && (total_q < expect_q);
   assign total_nxt = accept ? (total_q + CNT_W'(1)) : total_q;
   assign pending   = (pack_idx != '0) || (rx_level != '0);
   assign rx_ready  = (rx_level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q  <= '0;
         expect_q <= '0;
      end else if (arm_wr) begin
         total_q  <= '0;
         expect_q <= arm_count;
      end else begin
         total_q  <= total_nxt;
      end
   end

   rxp_lane_packer #(.WORD_W(WORD_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .byte_in   (rx_byte),
      .flush_req (stale_fire),
      .discard   (arm_wr),
      .push      (pk_push),
      .word      (pk_word),
      .fill      (pack_idx)
   );

   rxp_word_fifo #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (pk_push),
      .din     (pk_word),
      .pop_req (rd_en),
      .dout    (rd_word),
      .level   (rx_level)
   );

   rxp_stale_ctrl #(.CNT_W(CNT_W), .LIM_W(LIM_W), .DEF_STALE(DEF_STALE)) u_stale (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (char_tick),
      .byte_seen (rx_byte_vld),
      .pending   (pending),
      .cmd_op    (cmd_op),
      .limit_cfg (stale_chars),
      .arm       (arm_wr),
      .total_nxt (total_nxt),
      .fire      (stale_fire),
      .flag      (stale_flag),
      .snap      (snap_total),
      .snap_lock (snap_lock)
   );
endmodule

// File: rtl/rxp_word_packer_chk.sv
module rxp_word_packer_chk #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 64,
   parameter int CNT_W  = 16,
   parameter int IDX_W  = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rd_en,
   input logic                        arm_wr,
   input logic [WORD_W-1:0]           rd_word,
   input logic [$clog2(DEPTH+1)-1:0]  rx_level,
   input logic                        rx_ready,
   input logic                        stale_flag,
   input logic [CNT_W-1:0]            snap_total,
   input logic                        snap_lock,
   input logic [IDX_W-1:0]            pack_idx,
   input logic [CNT_W-1:0]            total_q,
   input logic [CNT_W-1:0]            expect_q
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rx_level) <= DEPTH); // R10

   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> (rd_word == '0)); // R3

   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rx_level == '0) |=> (32'(rx_level) <= 1)); // R3

   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((32'(rx_level) <= 32'($past(rx_level)) + 1) &&
                (32'(rx_level) + 1 >= 32'($past(rx_level))))); // R2

   AST_FLUSH_ON_STALE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stale_flag) |-> (pack_idx == '0)); // R7

   AST_SNAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_lock && !arm_wr) |=> $stable(snap_total)); // R8

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      total_q <= expect_q); // R5
endmodule

bind rxp_word_packer rxp_word_packer_chk #(
   .WORD_W (WORD_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .arm_wr     (arm_wr),
   .rd_word    (rd_word),
   .rx_level   (rx_level),
   .rx_ready   (rx_ready),
   .stale_flag (stale_flag),
   .snap_total (snap_total),
   .snap_lock  (snap_lock),
   .pack_idx   (pack_idx),
   .total_q    (total_q),
   .expect_q   (expect_q)
);

// File: tb/rxp_word_packer_tb.sv
`timescale 1ns/1ps
module rxp_word_packer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_byte_vld = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        char_tick = 1'b0;
   logic        arm_wr = 1'b0;
   logic [15:0] arm_count = '0;
   logic [2:0]  cmd_op = '0;
   logic [3:0]  stale_chars = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_word;
   logic [6:0]  rx_level;
   logic        rx_ready;
   logic        stale_flag;
   logic [15:0] snap_total;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rxp_word_packer dut_i (
      .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
      .char_tick(char_tick), .arm_wr(arm_wr), .arm_count(arm_count),
      .cmd_op(cmd_op), .stale_chars(stale_chars), .rd_en(rd_en),
      .rd_word(rd_word), .rx_level(rx_level), .rx_ready(rx_ready),
      .stale_flag(stale_flag), .snap_total(snap_total)
   );

   // behavioural reference model
   logic [31:0] m_q[$];
   int  m_lane[4];
   int  m_idx = 0, m_total = 0, m_expect = 0, m_cnt = 0, m_snap = 0;
   bit  m_en = 0, m_flag = 0, m_lock = 0;

   always @(posedge clk) begin
      int  lim;
      bit  pend, acc, fire, popd, full, have_w, hold;
      logic [31:0] wv;
      if (!rst_n) begin
         m_q.delete();
         foreach (m_lane[i]) m_lane[i] = 0;
         m_idx = 0; m_total = 0; m_expect = 0; m_cnt = 0; m_snap = 0;
         m_en = 0; m_flag = 0; m_lock = 0;
      end else begin
         lim  = (stale_chars == 0) ? 4 : int'(stale_chars);
         pend = (m_idx != 0) || (m_q.size() != 0);
         acc  = rx_byte_vld && !arm_wr && (m_total < m_expect);
         fire = (cmd_op == 3) ||
                (m_en && !m_flag && pend && !rx_byte_vld && char_tick && (m_cnt == lim - 1));
         popd = rd_en && (m_q.size() != 0);
         full = (m_q.size() == 64);
         hold = rx_byte_vld || !pend || m_flag || !m_en || fire || (cmd_op == 4);
         have_w = 0; wv = '0;
         if (acc) begin
            m_lane[m_idx] = int'(rx_byte); m_idx++; m_total++;
         end
         if (arm_wr) begin
            foreach (m_lane[i]) m_lane[i] = 0;
            m_idx = 0;
         end else if (m_idx == 4 || (fire && m_idx != 0)) begin
            for (int i = 0; i < 4; i++) wv[i*8 +: 8] = 8'(m_lane[i]);
            have_w = 1;
            foreach (m_lane[i]) m_lane[i] = 0;
            m_idx = 0;
         end
         if (hold) m_cnt = 0; else if (char_tick) m_cnt++;
         if (cmd_op == 1) m_en = 1; else if (cmd_op == 2) m_en = 0;
         if (cmd_op == 4) m_flag = 0; else if (fire) m_flag = 1;
         if (arm_wr) m_lock = 0;
         else if (fire && !m_lock) begin m_snap = m_total; m_lock = 1; end
         if (arm_wr) begin m_total = 0; m_expect = int'(arm_count); end
         if (popd) void'(m_q.pop_front());
         if (have_w && (!full || popd)) m_q.push_back(wv);
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      check("R3 rd_word vs model", rd_word, (m_q.size() != 0) ? m_q[0] : 32'h0);
      check("R2 rx_level vs model", rx_level, m_q.size());
      check("R2 rx_ready vs model", rx_ready, m_q.size() != 0);
      check("R6 stale_flag vs model", stale_flag, m_flag);
      check("R8 snap_total vs model", snap_total, m_snap);
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_model();
   endtask

   task automatic send(input logic [7:0] b);
      rx_byte_vld = 1; rx_byte = b; cyc(); rx_byte_vld = 0;
   endtask
   task automatic tick();
      char_tick = 1; cyc(); char_tick = 0;
   endtask
   task automatic cmd(input logic [2:0] op);
      cmd_op = op; cyc(); cmd_op = 0;
   endtask
   task automatic arm(input logic [15:0] n);
      arm_wr = 1; arm_count = n; cyc(); arm_wr = 0;
   endtask
   task automatic pop();
      rd_en = 1; cyc(); rd_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // reset state
      check("R2 level after reset", rx_level, 0);
      check("R2 ready after reset", rx_ready, 0);
      check("R8 snap after reset", snap_total, 0);
      check("R9 flag after reset", stale_flag, 0);
      check("R3 empty word after reset", rd_word, 0);

      // R5: nothing accepted before the first arm
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      check("R5 bytes before arm dropped", rx_level, 0);

      // R1: packing order
      arm(16'h2000); cmd(1);
      for (int i = 1; i <= 8; i++) send(8'(i));
      check("R2 two words stored", rx_level, 2);
      check("R1 first word little-endian", rd_word, 32'h04030201);
      pop();
      check("R1 second word", rd_word, 32'h08070605);
      pop();
      check("R3 drained", rx_level, 0);

      // R6/R7/R8: default four character times
      send(8'hA1); send(8'hA2); send(8'hA3);
      tick(); tick(); tick();
      check("R6 no stale after three ticks", stale_flag, 0);
      tick();
      check("R6 stale after four ticks", stale_flag, 1);
      check("R7 padded word stored", rx_level, 1);
      check("R7 padded word value", rd_word, 32'h00A3A2A1);
      check("R8 snapshot of eleven bytes", snap_total, 11);
      pop();

      // R9 clear, R6 restart on byte, R8 lock
      cmd(4);
      check("R9 clear drops flag", stale_flag, 0);
      stale_chars = 2;
      send(8'hB1); tick(); send(8'hB2); tick();
      check("R6 byte restarts timer", stale_flag, 0);
      tick();
      check("R6 stale after two ticks", stale_flag, 1);
      check("R7 second padded word", rd_word, 32'h0000B2B1);
      check("R8 snapshot held until re-arm", snap_total, 11);
      pop();

      // R3 empty read
      pop();
      check("R3 empty read keeps level", rx_level, 0);
      check("R3 empty read word zero", rd_word, 0);

      // R11 idle with nothing pending
      cmd(4);
      repeat (5) tick();
      check("R11 no stale with nothing pending", stale_flag, 0);

      // R9 force, disable, enable
      cmd(3);
      check("R9 force sets flag", stale_flag, 1);
      cmd(4); cmd(2);
      send(8'hC1);
      repeat (4) tick();
      check("R9 disabled timer never fires", stale_flag, 0);
      cmd(1); tick(); tick();
      check("R9 re-enabled timer fires", stale_flag, 1);
      check("R7 word after re-enable", rd_word, 32'h000000C1);
      pop(); cmd(4);

      // R4/R5/R8: short transfer
      arm(16'd5);
      for (int i = 0; i < 8; i++) send(8'hD0 + 8'(i));
      check("R5 one full word within count", rx_level, 1);
      cmd(3);
      check("R8 re-armed snapshot", snap_total, 5);
      check("R5 partial flushed", rx_level, 2);
      check("R1 full word of short transfer", rd_word, 32'hD3D2D1D0);
      pop();
      check("R5 last byte padded", rd_word, 32'h000000D4);
      pop(); cmd(4);

      // R4: arm beats byte, discards partial
      arm_wr = 1; arm_count = 16'h2000; rx_byte_vld = 1; rx_byte = 8'hEE;
      cyc(); arm_wr = 0; rx_byte_vld = 0;
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      send(8'h55); send(8'h66);
      arm(16'h2000);
      send(8'h77); send(8'h88); send(8'h99); send(8'hAA);
      check("R4 words after arm", rx_level, 2);
      check("R4 byte with arm dropped", rd_word, 32'h44332211);
      pop();
      check("R4 partial discarded by arm", rd_word, 32'hAA998877);
      pop();

      // R10 full FIFO
      for (int i = 0; i < 264; i++) send(8'(i));
      check("R10 level saturates", rx_level, 64);
      check("R10 oldest word kept", rd_word, 32'h03020100);
      pop();
      check("R10 level after one read", rx_level, 63);
      check("R10 next word", rd_word, 32'h07060504);
      while (rx_level != 0) pop();
      check("R2 ready low when drained", rx_ready, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule